// File: doc/BRIEF.md
# H-Bridge Mode and Fault Controller

This block turns a two-bit direction command into gate-enable commands for the four switches of a single H-bridge. It also handles the low-power sleep state and merges the protection inputs into one active-low fault flag meant for an open-drain pad. The PWM-on strobe comes from an external voltage regulation loop. During its off-time, both high-side switches conduct so the winding current recirculates. Gate changes on a leg pass through a dead-time gap, so a leg's high side and low side are never on at the same time.

The fault flag carries four kinds of fault, each with its own recovery:
- An overcurrent that outlasts a short deglitch window shuts the bridge down and latches until power returns.
- A sustained current limit raises the flag while driving carries on, and the flag clears by itself.
- Over-temperature disables the bridge and recovers by itself.
- Undervoltage disables everything and wipes all internal state.

Every exit from sleep also produces a fixed-length low pulse on the flag. A microsecond tick and a millisecond tick, both generated outside the block, give the timebase.

Top module: `hbridge_ctrl`

## Requirements
- R1: The direction code is {dir_a, dir_b}. With pwm_on high, 10 turns on the high side of leg A and the low side of leg B, 01 turns on the low side of leg A and the high side of leg B, and 11 turns on both high sides (brake). Code 00 turns off all four gates, sets sleep and clears bridge_en. All of these outputs are registered and take effect at the first clock edge after the input changes. In hs_en and ls_en, bit 0 is leg A and bit 1 is leg B.
- R2: In code 10 or 01, pwm_on low requests both high sides on and both low sides off.
- R3: The edge at which sleep falls (sleep is registered from the direction code) drives fault_n low. fault_n then stays low until PULSE_TICKS tick_us pulses have been counted after that edge.
- R4: While ilim_act is held in a non-sleep code, fault_n goes low at the ILIM_MS-th tick_ms pulse, and the gates keep driving. fault_n returns high at the first edge after ilim_act falls.
- R5: A sleep code clears the current-limit fault and its count at the next edge. No current-limit fault builds up while the block is asleep.
- R6: Any bit of ocp_hit held through OCP_US+1 tick_us pulses latches a shutdown. At that point fault_n goes low, and one edge later bridge_en drops and all gates turn off. A hold lasting only OCP_US pulses does not latch. Neither the direction code nor sleep clears the latch.
- R7: While ovt is high, fault_n is low. From the next edge, bridge_en is low and all gates are off. Drive resumes at the first edge after ovt falls.
- R8: uv drives fault_n low. From the next edge it holds sleep high and bridge_en low, and it clears the overcurrent latch and all counters. When uv falls in a non-sleep code, the bridge is re-enabled at the next edge and a sleep-exit pulse begins.
- R9: When a leg changes between high side and low side, both of its gates are off for DEAD_CYC clock cycles before the new switch turns on.
- R10: After reset, all gates are off, sleep is high, bridge_en is low and fault_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse each microsecond |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| dir_a | input | 1 | Direction bit, leg A drive request |
| dir_b | input | 1 | Direction bit, leg B drive request |
| pwm_on | input | 1 | Regulator PWM on-time strobe |
| ilim_act | input | 1 | Current limit engaged |
| ocp_hit | input | 4 | Per-switch overcurrent comparators |
| ovt | input | 1 | Over-temperature, hysteresis applied |
| uv | input | 1 | Supply undervoltage |
| hs_en | output | 2 | High-side gate enables, bit 0 = leg A |
| ls_en | output | 2 | Low-side gate enables, bit 0 = leg A |
| sleep | output | 1 | Block is in sleep |
| bridge_en | output | 1 | Bridge enabled |
| fault_n | output | 1 | Active-low fault flag |

## Verification
Gates, sleep and bridge_en come from registers, so each is due one edge after an input change. A dead-time transition shows an all-off state at that first edge, and the new switch appears DEAD_CYC edges later. fault_n is combinational from uv, ovt and the registered fault state, so it is due at the edge that loads the counter, latch or pulse. The one exception is the shutdown's effect on bridge_en and the gates, which lands one edge later. The bench drives each input and each tick as a one-cycle step just after a rising edge and samples just after the following edge. This lets it count the exact tick at which every count expires.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_t;
endpackage

// File: rtl/hb_leg.sv
module hb_leg
  import hb_pkg::*;
#(
  parameter int DEAD_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  leg_t req,
  output logic hi,
  output logic lo
);
  localparam int DW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);

  leg_t          cur_q, cur_d;
  logic [DW-1:0] dt_q, dt_d;

  always_comb begin
    cur_d = cur_q;
    dt_d  = dt_q;
    if (req == LEG_OFF) begin
      cur_d = LEG_OFF;
      if (cur_q != LEG_OFF)       dt_d = DW'(DEAD_CYC);
      else if (dt_q != '0)        dt_d = dt_q - 1'b1;
    end else if (req != cur_q) begin
      if (cur_q != LEG_OFF) begin
        cur_d = LEG_OFF;
        dt_d  = DW'(DEAD_CYC);
      end else if (dt_q <= DW'(1)) begin
        cur_d = req;
        dt_d  = '0;
      end else begin
        dt_d = dt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= LEG_OFF;
      dt_q  <= '0;
    end else begin
      cur_q <= cur_d;
      dt_q  <= dt_d;
    end
  end

  assign hi = (cur_q == LEG_HI);
  assign lo = (cur_q == LEG_LO);

  // R9: a switch only turns on after a cycle in which its partner was off
  p_dead_gap_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lo && !$past(lo)) |-> !$past(hi));
  p_dead_gap_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hi && !$past(hi)) |-> !$past(lo));
endmodule

// File: rtl/hb_fault.sv
module hb_fault #(
  parameter int OCP_US      = 3,
  parameter int ILIM_MS     = 275,
  parameter int PULSE_TICKS = 16,
  parameter int NSW         = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_us,
  input  logic           tick_ms,
  input  logic           sleep_req,
  input  logic           ilim_act,
  input  logic [NSW-1:0] ocp_hit,
  input  logic           ovt,
  input  logic           uv,
  output logic           sleep_q,
  output logic           ocp_latch,
  output logic           fault_n
);
  localparam int OW = $clog2(OCP_US + 1);
  localparam int IW = $clog2(ILIM_MS + 1);
  localparam int PW = $clog2(PULSE_TICKS + 1);

  logic          sleep_d;
  logic [OW-1:0] ocp_cnt_q, ocp_cnt_d;
  logic          latch_q, latch_d;
  logic [IW-1:0] ilim_cnt_q, ilim_cnt_d;
  logic          ilim_flt_q, ilim_flt_d;
  logic [PW-1:0] pulse_q, pulse_d;
  logic          ocp_any;

  assign ocp_any = |ocp_hit;

  always_comb begin
    sleep_d    = sleep_req;
    ocp_cnt_d  = ocp_cnt_q;
    latch_d    = latch_q;
    ilim_cnt_d = ilim_cnt_q;
    ilim_flt_d = ilim_flt_q;
    pulse_d    = pulse_q;
    if (uv) begin
      // supply loss wipes every piece of state
      sleep_d    = 1'b1;
      ocp_cnt_d  = '0;
      latch_d    = 1'b0;
      ilim_cnt_d = '0;
      ilim_flt_d = 1'b0;
      pulse_d    = '0;
    end else begin
      // overcurrent deglitch, then latch
      if (latch_q || !ocp_any) begin
        ocp_cnt_d = '0;
      end else if (tick_us) begin
        if (ocp_cnt_q == OW'(OCP_US)) latch_d = 1'b1;
        else                          ocp_cnt_d = ocp_cnt_q + 1'b1;
      end
      // current-limit persistence fault
      if (sleep_req || !ilim_act) begin
        ilim_cnt_d = '0;
        ilim_flt_d = 1'b0;
      end else if (tick_ms && !ilim_flt_q) begin
        if (ilim_cnt_q == IW'(ILIM_MS - 1)) ilim_flt_d = 1'b1;
        else                                ilim_cnt_d = ilim_cnt_q + 1'b1;
      end
      // sleep-exit pulse
      if (sleep_q && !sleep_req)          pulse_d = PW'(PULSE_TICKS);
      else if (tick_us && pulse_q != '0)  pulse_d = pulse_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q    <= 1'b1;
      ocp_cnt_q  <= '0;
      latch_q    <= 1'b0;
      ilim_cnt_q <= '0;
      ilim_flt_q <= 1'b0;
      pulse_q    <= '0;
    end else begin
      sleep_q    <= sleep_d;
      ocp_cnt_q  <= ocp_cnt_d;
      latch_q    <= latch_d;
      ilim_cnt_q <= ilim_cnt_d;
      ilim_flt_q <= ilim_flt_d;
      pulse_q    <= pulse_d;
    end
  end

  assign ocp_latch = latch_q;
  assign fault_n   = !(uv || ovt || latch_q || ilim_flt_q || (pulse_q != '0));

  p_exit_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_q) |-> !fault_n);
  p_ilim_sleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> !ilim_flt_q);
  p_ocp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !uv) |=> latch_q);
  p_uv_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uv |=> (sleep_q && !latch_q && pulse_q == '0));
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
  import hb_pkg::*;
#(
  parameter int OCP_US      = 3,
  parameter int ILIM_MS     = 275,
  parameter int PULSE_TICKS = 16,
  parameter int DEAD_CYC    = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_us,
  input  logic       tick_ms,
  input  logic       dir_a,
  input  logic       dir_b,
  input  logic       pwm_on,
  input  logic       ilim_act,
  input  logic [3:0] ocp_hit,
  input  logic       ovt,
  input  logic       uv,
  output logic [1:0] hs_en,
  output logic [1:0] ls_en,
  output logic       sleep,
  output logic       bridge_en,
  output logic       fault_n
);
  localparam int NLEG = 2;
  localparam int NSW  = 2 * NLEG;

  leg_t req [NLEG];
  logic sleep_req, ocp_latch, en_d, en_q;

  assign sleep_req = !dir_a && !dir_b;
  assign en_d      = !sleep_req && !uv && !ocp_latch && !ovt;

  always_comb begin
    req[0] = LEG_OFF;
    req[1] = LEG_OFF;
    if (en_d) begin
      unique case ({dir_a, dir_b})
        2'b10: begin
          req[0] = LEG_HI;
          req[1] = pwm_on ? LEG_LO : LEG_HI;
        end
        2'b01: begin
          req[0] = pwm_on ? LEG_LO : LEG_HI;
          req[1] = LEG_HI;
        end
        2'b11: begin
          req[0] = LEG_HI;
          req[1] = LEG_HI;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (req[g]),
      .hi   (hs_en[g]),
      .lo   (ls_en[g])
    );
  end

  hb_fault #(
    .OCP_US     (OCP_US),
    .ILIM_MS    (ILIM_MS),
    .PULSE_TICKS(PULSE_TICKS),
    .NSW        (NSW)
  ) u_fault (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_us  (tick_us),
    .tick_ms  (tick_ms),
    .sleep_req(sleep_req),
    .ilim_act (ilim_act),
    .ocp_hit  (ocp_hit),
    .ovt      (ovt),
    .uv       (uv),
    .sleep_q  (sleep),
    .ocp_latch(ocp_latch),
    .fault_n  (fault_n)
  );

  assign bridge_en = en_q;

  p_gates_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bridge_en |-> (hs_en == 2'b00 && ls_en == 2'b00));
  p_sleep_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !bridge_en);
  p_ovt_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovt |=> !bridge_en);
endmodule

// File: tb/sim_hbridge_ctrl.sv
`timescale 1ns/1ps
module sim_hbridge_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_us = 1'b0, tick_ms = 1'b0;
  logic       dir_a = 1'b0, dir_b = 1'b0, pwm_on = 1'b1;
  logic       ilim_act = 1'b0, ovt = 1'b0, uv = 1'b0;
  logic [3:0] ocp_hit = 4'b0;
  logic [1:0] hs_en, ls_en;
  logic       sleep, bridge_en, fault_n;

  int errors = 0;
  int checks = 0;
  int wd = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hbridge_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .tick_ms(tick_ms),
    .dir_a(dir_a), .dir_b(dir_b), .pwm_on(pwm_on), .ilim_act(ilim_act),
    .ocp_hit(ocp_hit), .ovt(ovt), .uv(uv), .hs_en(hs_en), .ls_en(ls_en),
    .sleep(sleep), .bridge_en(bridge_en), .fault_n(fault_n)
  );

  // gate vector {hs[1],hs[0],ls[1],ls[0]}
  localparam logic [3:0] G_OFF = 4'b0000, G_FWD = 4'b0110, G_REV = 4'b1001,
                         G_BRK = 4'b1100, G_AHI = 4'b0100, G_BHI = 4'b1000;

  function automatic logic [3:0] gates();
    return {hs_en, ls_en};
  endfunction

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 100000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", wd);
      report();
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic us_ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_us = 1'b1; cyc(); tick_us = 1'b0;
    end
  endtask

  task automatic ms_ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_ms = 1'b1; cyc(); tick_ms = 1'b0;
    end
  endtask

  task automatic set_dir(logic [1:0] d);
    {dir_a, dir_b} = d;
  endtask

  // enter forward drive from sleep and let the exit pulse expire
  task automatic go_forward();
    set_dir(2'b00); pwm_on = 1'b1; cyc(2);
    set_dir(2'b10); cyc();
    us_ticks(16);
  endtask

  task automatic t_reset();
    chk("R10 gates", 8'(gates()), 8'(G_OFF));
    chk("R10 sleep", 8'(sleep), 8'd1);
    chk("R10 bridge_en", 8'(bridge_en), 8'd0);
    chk("R10 fault_n", 8'(fault_n), 8'd1);
  endtask

  task automatic t_modes();
    set_dir(2'b10); pwm_on = 1'b1; cyc();
    chk("R1 forward", 8'(gates()), 8'(G_FWD));
    chk("R1 bridge_en", 8'(bridge_en), 8'd1);
    set_dir(2'b01); cyc();
    chk("R9 gap fwd->rev", 8'(gates()), 8'(G_OFF));
    cyc();
    chk("R1 reverse", 8'(gates()), 8'(G_REV));
    set_dir(2'b11); cyc();
    chk("R9 gap leg A", 8'(gates()), 8'(G_BHI));
    cyc();
    chk("R1 brake", 8'(gates()), 8'(G_BRK));
    set_dir(2'b00); cyc();
    chk("R1 sleep gates", 8'(gates()), 8'(G_OFF));
    chk("R1 sleep flag", 8'(sleep), 8'd1);
    chk("R1 sleep bridge", 8'(bridge_en), 8'd0);
  endtask

  task automatic t_pwm_off();
    go_forward();
    pwm_on = 1'b0; cyc();
    chk("R9 gap leg B", 8'(gates()), 8'(G_AHI));
    cyc();
    chk("R2 recirculate", 8'(gates()), 8'(G_BRK));
    pwm_on = 1'b1; cyc(2);
    chk("R2 back on", 8'(gates()), 8'(G_FWD));
  endtask

  task automatic t_exit_pulse();
    set_dir(2'b00); cyc(3);
    chk("R3 asleep no fault", 8'(fault_n), 8'd1);
    set_dir(2'b10); cyc();
    chk("R3 pulse start", 8'(fault_n), 8'd0);
    cyc(5);
    chk("R3 waits ticks", 8'(fault_n), 8'd0);
    us_ticks(15);
    chk("R3 pulse tick 15", 8'(fault_n), 8'd0);
    us_ticks(1);
    chk("R3 pulse end", 8'(fault_n), 8'd1);
  endtask

  task automatic t_ilim();
    go_forward();
    ilim_act = 1'b1;
    ms_ticks(274);
    chk("R4 before limit", 8'(fault_n), 8'd1);
    ms_ticks(1);
    chk("R4 fault", 8'(fault_n), 8'd0);
    chk("R4 still driving", 8'(gates()), 8'(G_FWD));
    ilim_act = 1'b0; cyc();
    chk("R4 self clear", 8'(fault_n), 8'd1);
  endtask

  task automatic t_ilim_sleep();
    ilim_act = 1'b1;
    ms_ticks(275);
    chk("R5 fault set", 8'(fault_n), 8'd0);
    set_dir(2'b00); cyc();
    chk("R5 sleep clears", 8'(fault_n), 8'd1);
    ms_ticks(300);
    chk("R5 no build in sleep", 8'(fault_n), 8'd1);
    set_dir(2'b10); cyc();
    us_ticks(16);
    chk("R5 count restarted", 8'(fault_n), 8'd1);
    ilim_act = 1'b0; cyc();
  endtask

  task automatic t_ocp_uv();
    go_forward();
    ocp_hit = 4'b0100;
    us_ticks(3);
    ocp_hit = 4'b0000; cyc();
    chk("R6 short no latch", 8'(fault_n), 8'd1);
    chk("R6 short bridge on", 8'(bridge_en), 8'd1);
    ocp_hit = 4'b0100;
    us_ticks(3);
    chk("R6 deglitch", 8'(fault_n), 8'd1);
    us_ticks(1);
    chk("R6 latch fault", 8'(fault_n), 8'd0);
    cyc();
    chk("R6 bridge off", 8'(bridge_en), 8'd0);
    chk("R6 gates off", 8'(gates()), 8'(G_OFF));
    ocp_hit = 4'b0000;
    set_dir(2'b00); cyc(2);
    set_dir(2'b10); cyc(2);
    chk("R6 held thru sleep", 8'(bridge_en), 8'd0);
    chk("R6 fault held", 8'(fault_n), 8'd0);
    uv = 1'b1;
    #0;
    chk("R8 uv fault", 8'(fault_n), 8'd0);
    cyc();
    chk("R8 sleep", 8'(sleep), 8'd1);
    chk("R8 bridge off", 8'(bridge_en), 8'd0);
    uv = 1'b0; cyc();
    chk("R8 latch cleared", 8'(bridge_en), 8'd1);
    chk("R8 drive back", 8'(gates()), 8'(G_FWD));
    chk("R8 exit pulse", 8'(fault_n), 8'd0);
    us_ticks(16);
    chk("R8 fault released", 8'(fault_n), 8'd1);
  endtask

  task automatic t_ovt();
    ovt = 1'b1; cyc();
    chk("R7 fault", 8'(fault_n), 8'd0);
    chk("R7 bridge off", 8'(bridge_en), 8'd0);
    chk("R7 gates off", 8'(gates()), 8'(G_OFF));
    ovt = 1'b0; cyc();
    chk("R7 resume", 8'(bridge_en), 8'd1);
    chk("R7 gates back", 8'(gates()), 8'(G_FWD));
    chk("R7 fault clear", 8'(fault_n), 8'd1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_modes();
    t_pwm_off();
    t_exit_pulse();
    t_ilim();
    t_ilim_sleep();
    t_ocp_uv();
    t_ovt();
    done = 1;
    report();
  end
endmodule